// File: doc/BRIEF.md
# Bus-Safe Edge Event Capture Register

This block sits between a bank of already-debounced input channels and a host bus. It keeps three host-readable views of the channels: a live level register, a sticky register of rising edges and a sticky register of falling edges. Edges are found by comparing each new synchronised sample of a channel with the sample before it.

While the host bus has a transaction in progress, the block freezes the input sample in a holding register. The freeze lasts for the whole transaction and then for a fixed guard time after it. The held value passes through a multi-stage synchroniser before it reaches the registers, so a host read never sees a torn value. An edge that arrives during the freeze is not dropped. It is recorded on the first sample taken after the hold opens again. A pulse that starts and ends inside one freeze leaves no trace.

The host clears event bits by writing 1s to them. A mask register chooses which event bits drive the interrupt, so the host can either take interrupts or poll the event registers.

Top module: `evcap_top`

The hold controller has three states:
- `ST_OPEN`: the input is sampled every cycle.
- `ST_FROZEN`: a transaction is in progress.
- `ST_GUARD`: the guard time is counting down.

It has these transitions:
- OPEN→FROZEN when `bus_busy` is seen high.
- FROZEN→GUARD when `bus_busy` falls. The guard counter starts at zero.
- GUARD→FROZEN when `bus_busy` rises again.
- GUARD→OPEN after `GUARD_CYCLES` cycles in GUARD.
- Every other case stays in the same state.

## Requirements
- R1: With no transaction and no guard time running, a channel level on `din` before clock edge k appears on `data_out` after edge k+3. The path is one holding stage and two synchroniser stages, then the data register.
- R2: On any cycle where `bus_busy` is high, or where the controller is in FROZEN or GUARD, the holding register keeps its value, so `data_out` does not follow `din`.
- R3: After `bus_busy` falls, the hold stays closed for `GUARD_CYCLES` more cycles. `GUARD_CYCLES` is derived from the clock frequency and a 500 ns guard time, which gives 25 cycles at 50 MHz. `hold_active` is high exactly while the controller is in FROZEN or GUARD.
- R4: A level change that happens during a hold is captured on the first sample after the hold opens. It then reaches `data_out` and sets the matching edge bit.
- R5: A bit of `rise_out` is set when that channel's data register goes from 0 to 1. A bit of `fall_out` is set when it goes from 1 to 0.
- R6: Event bits are sticky. A bit is cleared only by a 1 at the same position of `rise_clr` or `fall_clr`, and a 0 there has no effect.
- R7: If an edge and a clear hit the same event bit on the same clock edge, the bit stays set.
- R8: When `mask_we` is high, `mask_wdata` is loaded into the mask register, which is readable on `mask_out`. Otherwise the mask keeps its value.
- R9: `irq` is high exactly when some bit set in `rise_out` or `fall_out` has its mask bit set.
- R10: A pulse on a channel that starts and ends inside one hold produces no event and no change on `data_out`.
- R11: After reset, all registers read zero, `irq` is low and the controller is in OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NCH | Debounced channel levels |
| bus_busy | input | 1 | High while a host bus transaction is in progress |
| rise_clr | input | NCH | Write-1-to-clear strobes for rising-edge events |
| fall_clr | input | NCH | Write-1-to-clear strobes for falling-edge events |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | NCH | Mask register write data |
| data_out | output | NCH | Live level register |
| rise_out | output | NCH | Sticky rising-edge events |
| fall_out | output | NCH | Sticky falling-edge events |
| mask_out | output | NCH | Interrupt mask register |
| irq | output | 1 | Interrupt request |
| hold_active | output | 1 | Inputs are frozen (FROZEN or GUARD) |

## Verification
The bench checks the length of the guard window exactly. A counter that is off by one would release the hold one cycle early or late, and the level would reach `data_out` in the wrong cycle. It changes inputs during a hold and checks that the edge is recorded after release. A design that samples during the hold would show the change early, and a design that drops it would never set the event bit. It also places a short pulse wholly inside a hold, which must leave no event, and it clears a bit on the same cycle that an edge sets it, where a design that gives priority to the clear would lose the event. Random traffic with back-to-back transactions, including ones that restart during the guard time, is compared with a behavioural model on every clock.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_FROZEN = 2'd1,
        ST_GUARD  = 2'd2
    } hold_state_t;

    function automatic int guard_cycles(input longint clk_hz, input int guard_ns);
        longint prod;
        prod = clk_hz * guard_ns;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction
endpackage

// File: rtl/evcap_hold_ctrl.sv
module evcap_hold_ctrl
    import evcap_pkg::*;
#(
    parameter int GUARD_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_busy,
    output logic cap_en,
    output logic hold_active
);
    localparam int CW = $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GUARD_CYCLES - 1);

    hold_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                if (bus_busy) state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!bus_busy) begin
                    state_d = ST_GUARD;
                    cnt_d   = '0;
                end
            end
            ST_GUARD: begin
                if (bus_busy) begin
                    state_d = ST_FROZEN;
                end else if (cnt_q == LAST) begin
                    state_d = ST_OPEN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        cap_en      = 1'b0;
        hold_active = 1'b1;
        unique case (state_q)
            ST_OPEN: begin
                cap_en      = !bus_busy;
                hold_active = 1'b0;
            end
            ST_FROZEN, ST_GUARD: begin
                cap_en      = 1'b0;
                hold_active = 1'b1;
            end
            default: begin
                cap_en      = 1'b0;
                hold_active = 1'b1;
            end
        endcase
    end

    a_r2_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> state_q == ST_FROZEN);
    a_r3_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && !bus_busy && cnt_q != LAST) |=> state_q == ST_GUARD);
    a_r3_guard_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && !bus_busy && cnt_q == LAST) |=> state_q == ST_OPEN);
endmodule

// File: rtl/evcap_hold_sync.sv
module evcap_hold_sync #(
    parameter int NCH         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] sync_out
);
    logic [NCH-1:0] hold_q;
    logic [NCH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (cap_en) hold_q <= din;
    end

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= hold_q;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[SYNC_STAGES-1];

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(hold_q));
endmodule

// File: rtl/evcap_event_regs.sv
module evcap_event_regs #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sample,
    input  logic [NCH-1:0] rise_clr,
    input  logic [NCH-1:0] fall_clr,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    output logic [NCH-1:0] data_q,
    output logic [NCH-1:0] rise_q,
    output logic [NCH-1:0] fall_q,
    output logic [NCH-1:0] mask_q,
    output logic           irq
);
    logic [NCH-1:0] up_edge, dn_edge;

    always_comb begin
        up_edge = sample & ~data_q;
        dn_edge = ~sample & data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '0;
        end else begin
            data_q <= sample;
            // a new edge wins over a clear in the same cycle
            rise_q <= (rise_q & ~rise_clr) | up_edge;
            fall_q <= (fall_q & ~fall_clr) | dn_edge;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq = |((rise_q | fall_q) & mask_q);

    a_r5_rise_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q & ~$past(data_q)) & ~rise_q) == '0);
    a_r5_fall_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        ((~data_q & $past(data_q)) & ~fall_q) == '0);
    a_r6_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_q) |=> ((rise_q & $past(rise_q & ~rise_clr)) == $past(rise_q & ~rise_clr)));
    a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: rtl/evcap_top.sv
module evcap_top #(
    parameter int     NCH         = 32,
    parameter int     SYNC_STAGES = 2,
    parameter longint CLK_HZ      = 50_000_000,
    parameter int     GUARD_NS    = 500
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    input  logic           bus_busy,
    input  logic [NCH-1:0] rise_clr,
    input  logic [NCH-1:0] fall_clr,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    output logic [NCH-1:0] data_out,
    output logic [NCH-1:0] rise_out,
    output logic [NCH-1:0] fall_out,
    output logic [NCH-1:0] mask_out,
    output logic           irq,
    output logic           hold_active
);
    localparam int GC_RAW       = evcap_pkg::guard_cycles(CLK_HZ, GUARD_NS);
    localparam int GUARD_CYCLES = (GC_RAW < 1) ? 1 : GC_RAW;

    logic           cap_en;
    logic [NCH-1:0] sync_out;

    evcap_hold_ctrl #(.GUARD_CYCLES(GUARD_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_busy   (bus_busy),
        .cap_en     (cap_en),
        .hold_active(hold_active)
    );

    evcap_hold_sync #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .din     (din),
        .sync_out(sync_out)
    );

    evcap_event_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sync_out),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .data_q    (data_out),
        .rise_q    (rise_out),
        .fall_q    (fall_out),
        .mask_q    (mask_out),
        .irq       (irq)
    );

    a_r3_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> hold_active);
endmodule

// File: tb/evcap_top_test.sv
module evcap_top_test;
    localparam int N = 8;
    localparam int G = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] din = '0, rise_clr = '0, fall_clr = '0, mask_wdata = '0;
    logic         bus_busy = 1'b0, mask_we = 1'b0;
    logic [N-1:0] data_out, rise_out, fall_out, mask_out;
    logic         irq, hold_active;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    evcap_top #(.NCH(N)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .bus_busy(bus_busy),
        .rise_clr(rise_clr), .fall_clr(fall_clr), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .data_out(data_out), .rise_out(rise_out),
        .fall_out(fall_out), .mask_out(mask_out), .irq(irq),
        .hold_active(hold_active)
    );

    // behavioural reference model
    int           m_mode = 0;
    int           m_cnt  = 0;
    logic [N-1:0] m_hv = '0, m_d = '0, m_r = '0, m_f = '0, m_m = '0;
    logic [N-1:0] m_q[$] = '{8'h00, 8'h00};

    always @(posedge clk) begin
        logic [N-1:0] nd;
        bit open;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_hv = '0; m_d = '0; m_r = '0; m_f = '0; m_m = '0;
            m_q = '{8'h00, 8'h00};
        end else begin
            open = (m_mode == 0) && !bus_busy;
            nd = m_q.pop_front();
            m_q.push_back(m_hv);
            if (open) m_hv = din;
            m_r = (m_r & ~rise_clr) | (nd & ~m_d);
            m_f = (m_f & ~fall_clr) | (~nd & m_d);
            m_d = nd;
            if (mask_we) m_m = mask_wdata;
            case (m_mode)
                0: if (bus_busy) m_mode = 1;
                1: if (!bus_busy) begin m_mode = 2; m_cnt = 0; end
                default: begin
                    if (bus_busy) m_mode = 1;
                    else if (m_cnt == G - 1) m_mode = 0;
                    else m_cnt++;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison, 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk("R1 data", data_out, m_d);
            chk("R5 rise", rise_out, m_r);
            chk("R5 fall", fall_out, m_f);
            chk("R8 mask", mask_out, m_m);
            chk("R9 irq", N'(irq), N'(|((m_r | m_f) & m_m)));
            chk("R3 hold", N'(hold_active), N'(m_mode != 0));
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        // R11 reset state
        chk("R11 data", data_out, '0);
        chk("R11 events", rise_out | fall_out, '0);
        chk("R11 irq", N'(irq), '0);
        chk("R11 hold", N'(hold_active), '0);
        rst_n = 1'b1;
        step(2);

        // R1 latency: visible after the fourth edge
        din = 8'hA5;
        step(3);
        chk("R1 not yet", data_out, 8'h00);
        step(1);
        chk("R1 arrived", data_out, 8'hA5);
        chk("R5 rise set", rise_out, 8'hA5);

        // R6 clear with 1s, 0s ignored
        rise_clr = 8'h0F;
        step(1);
        rise_clr = '0;
        chk("R6 partial clear", rise_out, 8'hA0);
        rise_clr = 8'hFF;
        step(1);
        rise_clr = '0;
        step(2);
        chk("R6 cleared", rise_out, 8'h00);

        // R2 freeze during transaction, R3 guard, R4 late capture
        bus_busy = 1'b1;
        step(1);
        din = 8'h5A;
        step(10);
        chk("R2 frozen", data_out, 8'hA5);
        bus_busy = 1'b0;
        step(G - 1);
        chk("R3 still frozen", data_out, 8'hA5);
        chk("R3 hold flag", N'(hold_active), N'(1));
        step(6);
        chk("R4 captured", data_out, 8'h5A);
        chk("R4 rise", rise_out, 8'h5A);
        chk("R4 fall", fall_out, 8'hA5);

        // R10 pulse inside a hold
        rise_clr = 8'hFF; fall_clr = 8'hFF;
        step(1);
        rise_clr = '0; fall_clr = '0;
        bus_busy = 1'b1;
        step(1);
        din = 8'hFF;
        step(2);
        din = 8'h5A;
        step(1);
        bus_busy = 1'b0;
        step(G + 8);
        chk("R10 no rise", rise_out, 8'h00);
        chk("R10 no fall", fall_out, 8'h00);
        chk("R10 data", data_out, 8'h5A);

        // R7 edge and clear in the same cycle
        din = 8'h5B;
        step(3);
        rise_clr = 8'hFF;
        step(1);
        rise_clr = '0;
        chk("R7 set wins", rise_out, 8'h01);

        // R8 / R9 mask and interrupt
        chk("R9 masked off", N'(irq), '0);
        mask_we = 1'b1; mask_wdata = 8'h01;
        step(1);
        mask_we = 1'b0; mask_wdata = 8'hFF;
        step(1);
        chk("R8 mask loaded", mask_out, 8'h01);
        chk("R9 irq up", N'(irq), N'(1));
        rise_clr = 8'h01;
        step(1);
        rise_clr = '0;
        chk("R9 irq down", N'(irq), '0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) din = N'($urandom);
            if ($urandom_range(0, 30) == 0) bus_busy = ~bus_busy;
            rise_clr = ($urandom_range(0, 6) == 0) ? N'($urandom) : '0;
            fall_clr = ($urandom_range(0, 6) == 0) ? N'($urandom) : '0;
            mask_we = ($urandom_range(0, 20) == 0);
            mask_wdata = N'($urandom);
            step(1);
        end
        bus_busy = 1'b0;
        step(G + 10);
        finish_run();
    end
endmodule